// File: doc/BRIEF.md
# Stereo Soft-Mute Gain Ramp

This block fades a stereo sample stream in and out under a single mute control. Instead of cutting the signal at once, the gain slides down one step at a time to silence while mute is held high. When mute goes low, the gain climbs back up to full level the same way. The step size stays fixed, so a complete fade in either direction always takes the same number of sample periods.

Each sample period is marked by a one-cycle strobe. On that strobe the block captures the left and right samples, scales them by the current gain and holds the results on its outputs until the next strobe. The gain is an index from 0 to `GAIN_STEPS`, and the gain applied is index/`GAIN_STEPS`. With the defaults the gain moves by one index every 8 strobes, so a full fade from 128 to 0 takes 1024 sample periods.

A status output reports when the stream is completely silent. Mute pulses shorter than one gain step are outside the intended use. They are still handled safely, because a reversal simply turns the ramp around from wherever it is.

Top module: `softmute_ramp`

## Requirements
- R1: Reset is active high and synchronous. It sets the gain index to `GAIN_STEPS` (unity), clears both sample outputs to 0 and drives `fully_muted` low. This also holds when reset is applied in the middle of a ramp.
- R2: While `mute_req` is high and the gain index is above 0, the index drops by exactly one on every `STEP_SAMPLES`-th strobe. Counting from a resting unity state, `fully_muted` rises on strobe number `GAIN_STEPS*STEP_SAMPLES` (1024 by default) and not earlier.
- R3: While `mute_req` is low and the gain index is below `GAIN_STEPS`, the index rises by exactly one on every `STEP_SAMPLES`-th strobe. Starting from full mute, strobe number 1025 is the first strobe whose output equals its input.
- R4: With the gain index at `GAIN_STEPS`, an output equals the sample captured on the same strobe. With the index at 0, an output is exactly 0.
- R5: On each strobe, each output becomes sample*index/`GAIN_STEPS`, with the quotient truncated toward zero. The output is registered: it appears one clock after the strobe edge and uses the index in force before that edge's update.
- R6: `fully_muted` is high exactly when the gain index is 0.
- R7: If `mute_req` changes direction mid-ramp, the ramp reverses from the current index with no jump. The strobe phase counter keeps its count across the reversal.
- R8: Clock cycles without a strobe change neither the outputs nor the gain index, whatever the sample inputs do.
- R9: While the index rests at its target (0 when muted, `GAIN_STEPS` when unmuted), strobes do not advance the phase. After any change of `mute_req`, the first step therefore lands on the `STEP_SAMPLES`-th strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_req | input | 1 | High fades out, low fades in |
| sample_stb | input | 1 | One-cycle strobe per sample period |
| left_in | input | DATA_W | Left sample, two's complement |
| right_in | input | DATA_W | Right sample, two's complement |
| left_out | output | DATA_W | Scaled left sample |
| right_out | output | DATA_W | Scaled right sample |
| fully_muted | output | 1 | High while the gain index is 0 |

## Verification
The bench uses the default parameters: 16-bit samples, 128 gain steps and 8 strobes per step. With these values the full 1024-strobe fade in both directions is short enough to run completely, and the extreme input -32768 is reachable for the truncation checks. A sample of 12800 is exactly 100 per gain index, so every output directly reveals the gain index through the normal data path. The truncation table is applied at gain index 64, which makes the rounding toward zero of odd negative samples visible.

// File: rtl/softmute_pkg.sv
package softmute_pkg;

  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_DOWN = 2'd1,
    DIR_UP   = 2'd2
  } ramp_dir_e;

  // Direction of the ramp, from the request and where the gain sits
  function automatic ramp_dir_e pick_dir(logic mute, logic at_floor, logic at_ceiling);
    if (mute)
      return at_floor ? DIR_HOLD : DIR_DOWN;
    return at_ceiling ? DIR_HOLD : DIR_UP;
  endfunction

endpackage

// File: rtl/smr_step_timer.sv
module smr_step_timer #(
  parameter int STEP_SAMPLES = 8,
  localparam int PH_W = (STEP_SAMPLES > 1) ? $clog2(STEP_SAMPLES) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic stb,
  input  logic ramp_active,
  output logic step_evt
);

  localparam logic [PH_W-1:0] LAST_PH = PH_W'(STEP_SAMPLES - 1);

  logic [PH_W-1:0] phase;
  logic            phase_wrap;

  assign phase_wrap = (phase == LAST_PH);
  assign step_evt   = stb && ramp_active && phase_wrap;

  always_ff @(posedge clk) begin
    if (rst)
      phase <= '0;
    else if (stb) begin
      if (!ramp_active || phase_wrap)
        phase <= '0;
      else
        phase <= phase + PH_W'(1);
    end
  end

  assert_phase_range_R2: assert property (@(posedge clk) disable iff (rst)
    phase <= LAST_PH);

  assert_idle_phase_R9: assert property (@(posedge clk) disable iff (rst)
    (stb && !ramp_active) |=> (phase == '0));

  assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(phase));

endmodule

// File: rtl/smr_gain_ctrl.sv
module smr_gain_ctrl
  import softmute_pkg::*;
#(
  parameter int GAIN_STEPS = 128,
  localparam int GAIN_W = $clog2(GAIN_STEPS + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mute,
  input  logic              step_evt,
  output logic [GAIN_W-1:0] gain,
  output logic              ramp_active
);

  localparam logic [GAIN_W-1:0] GAIN_MAX = GAIN_W'(GAIN_STEPS);

  ramp_dir_e dir;

  assign dir         = pick_dir(mute, gain == '0, gain == GAIN_MAX);
  assign ramp_active = (dir != DIR_HOLD);

  always_ff @(posedge clk) begin
    if (rst)
      gain <= GAIN_MAX;
    else if (step_evt) begin
      case (dir)
        DIR_DOWN: gain <= gain - GAIN_W'(1);
        DIR_UP:   gain <= gain + GAIN_W'(1);
        default:  gain <= gain;
      endcase
    end
  end

  assert_gain_range_R6: assert property (@(posedge clk) disable iff (rst)
    gain <= GAIN_MAX);

  assert_gain_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !step_evt |=> $stable(gain));

  assert_gain_down_R2: assert property (@(posedge clk) disable iff (rst)
    (step_evt && mute) |=> (gain == $past(gain) - GAIN_W'(1)));

  assert_gain_up_R3: assert property (@(posedge clk) disable iff (rst)
    (step_evt && !mute) |=> (gain == $past(gain) + GAIN_W'(1)));

endmodule

// File: rtl/smr_scaler.sv
module smr_scaler #(
  parameter int DATA_W     = 16,
  parameter int GAIN_W     = 8,
  parameter int GAIN_SHIFT = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     stb,
  input  logic signed [DATA_W-1:0] sample,
  input  logic        [GAIN_W-1:0] gain,
  output logic signed [DATA_W-1:0] scaled
);

  localparam int PW = DATA_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] BIAS = PW'((1 << GAIN_SHIFT) - 1);
  localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1 << GAIN_SHIFT);

  // sample * gain / 2^GAIN_SHIFT, quotient truncated toward zero
  function automatic logic signed [DATA_W-1:0] attenuate(
    logic signed [DATA_W-1:0] s, logic [GAIN_W-1:0] g);
    logic signed [PW-1:0] se, ge, prod;
    se   = PW'(s);
    ge   = $signed(PW'({1'b0, g}));
    prod = se * ge;
    if (prod < 0)
      prod = prod + BIAS;
    return DATA_W'(prod >>> GAIN_SHIFT);
  endfunction

  always_ff @(posedge clk) begin
    if (rst)
      scaled <= '0;
    else if (stb)
      scaled <= attenuate(sample, gain);
  end

  assert_unity_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (stb && gain == UNITY) |=> (scaled == $past(sample)));

  assert_zero_out_R4: assert property (@(posedge clk) disable iff (rst)
    (stb && gain == '0) |=> (scaled == '0));

  assert_no_sign_flip_R5: assert property (@(posedge clk) disable iff (rst)
    (stb && sample >= 0) |=> (scaled >= 0));

  assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !stb |=> $stable(scaled));

endmodule

// File: rtl/softmute_ramp.sv
module softmute_ramp #(
  parameter int DATA_W       = 16,
  parameter int GAIN_STEPS   = 128,
  parameter int STEP_SAMPLES = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     mute_req,
  input  logic                     sample_stb,
  input  logic signed [DATA_W-1:0] left_in,
  input  logic signed [DATA_W-1:0] right_in,
  output logic signed [DATA_W-1:0] left_out,
  output logic signed [DATA_W-1:0] right_out,
  output logic                     fully_muted
);

  localparam int GAIN_W     = $clog2(GAIN_STEPS + 1);
  localparam int GAIN_SHIFT = $clog2(GAIN_STEPS);
  localparam int N_CH       = 2;

  logic              step_evt;
  logic              ramp_active;
  logic [GAIN_W-1:0] gain;

  logic signed [DATA_W-1:0] ch_in  [N_CH];
  logic signed [DATA_W-1:0] ch_out [N_CH];

  smr_step_timer #(.STEP_SAMPLES(STEP_SAMPLES)) u_timer (
    .clk         (clk),
    .rst         (rst),
    .stb         (sample_stb),
    .ramp_active (ramp_active),
    .step_evt    (step_evt)
  );

  smr_gain_ctrl #(.GAIN_STEPS(GAIN_STEPS)) u_gain (
    .clk         (clk),
    .rst         (rst),
    .mute        (mute_req),
    .step_evt    (step_evt),
    .gain        (gain),
    .ramp_active (ramp_active)
  );

  assign ch_in[0] = left_in;
  assign ch_in[1] = right_in;

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    smr_scaler #(
      .DATA_W     (DATA_W),
      .GAIN_W     (GAIN_W),
      .GAIN_SHIFT (GAIN_SHIFT)
    ) u_scl (
      .clk    (clk),
      .rst    (rst),
      .stb    (sample_stb),
      .sample (ch_in[c]),
      .gain   (gain),
      .scaled (ch_out[c])
    );
  end

  assign left_out    = ch_out[0];
  assign right_out   = ch_out[1];
  assign fully_muted = (gain == '0);

  assert_mute_entry_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(fully_muted) |-> $past(mute_req));

  assert_mute_exit_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(fully_muted) |-> !$past(mute_req));

  assert_silent_out_R4: assert property (@(posedge clk) disable iff (rst)
    (sample_stb && fully_muted) |=> (left_out == '0 && right_out == '0));

endmodule

// File: tb/sim_softmute_ramp.sv
module sim_softmute_ramp;

  localparam int CLK_PERIOD = 10;
  localparam int GS = 128;
  localparam int SS = 8;

  // {sample, expected at gain index 64}
  localparam int VEC [8][2] = '{
    '{100, 50}, '{-100, -50}, '{-3, -1}, '{3, 1},
    '{32767, 16383}, '{-32768, -16384}, '{1, 0}, '{-1, 0}
  };

  logic clk = 0;
  logic rst = 1;
  logic mute_req = 0;
  logic sample_stb = 0;
  logic signed [15:0] left_in = 0, right_in = 0;
  logic signed [15:0] left_out, right_out;
  logic fully_muted;

  int total = 0, bad = 0;
  int mgain = GS, mphase = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  softmute_ramp u0 (
    .clk(clk), .rst(rst), .mute_req(mute_req), .sample_stb(sample_stb),
    .left_in(left_in), .right_in(right_in),
    .left_out(left_out), .right_out(right_out), .fully_muted(fully_muted)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk) rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    mgain = GS; mphase = 0;
  endtask

  // one strobe; outputs compared against the model, then model advances
  task automatic strobe(input int l, input int r, input string req);
    int el, er;
    @(negedge clk);
    sample_stb = 1; left_in = 16'(l); right_in = 16'(r);
    @(negedge clk);
    sample_stb = 0;
    el = (l * mgain) / GS;
    er = (r * mgain) / GS;
    check(req, int'(left_out), el);
    check(req, int'(right_out), er);
    if (mgain == (mute_req ? 0 : GS)) mphase = 0;
    else if (mphase == SS - 1) begin
      mphase = 0;
      mgain += mute_req ? -1 : 1;
    end else mphase++;
    check("R6", int'(fully_muted), int'(mgain == 0));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n;
    int hl, hr;
    do_reset();
    // R1: reset state
    check("R1", int'(left_out), 0);
    check("R1", int'(right_out), 0);
    check("R1", int'(fully_muted), 0);

    // R4: unity pass, idle strobes (R9)
    strobe(1234, -32768, "R4");
    strobe(-7, 32767, "R4");
    repeat (10) strobe(12800, -12800, "R9");

    // R8: no strobe, inputs wiggle, nothing moves
    hl = int'(left_out); hr = int'(right_out);
    repeat (5) begin
      @(negedge clk) left_in = 16'sd999; right_in = -16'sd5;
    end
    check("R8", int'(left_out), hl);
    check("R8", int'(right_out), hr);

    // R2: fade to gain 64 (first step on 8th strobe per R9)
    @(negedge clk) mute_req = 1;
    for (int i = 0; i < 7; i++) strobe(12800, 12800, "R9");
    strobe(12800, 12800, "R9");
    strobe(12800, 12800, "R2");
    check("R9", int'(left_out), 12700);
    for (int i = 0; i < 503; i++) strobe(12800, -12800, "R2");
    check("R2", mgain, 64);

    // R5: truncation table at gain 64
    for (int i = 0; i < 8; i++) begin
      strobe(VEC[i][0], VEC[7-i][0], "R5");
      check("R5", int'(left_out), VEC[i][1]);
      check("R5", int'(right_out), VEC[7-i][1]);
    end

    // R7: reversal mid-ramp keeps gain and phase (gain 63, phase 0)
    repeat (3) strobe(12800, 12800, "R7");
    @(negedge clk) mute_req = 0;
    repeat (4) strobe(12800, 12800, "R7");
    strobe(12800, 12800, "R7");
    check("R7", int'(left_out), 6300);
    strobe(12800, 12800, "R7");
    check("R7", int'(left_out), 6400);

    // R1: reset mid-ramp
    @(negedge clk) mute_req = 1;
    repeat (20) strobe(12800, 12800, "R2");
    @(negedge clk) mute_req = 0;
    do_reset();
    check("R1", int'(left_out), 0);
    check("R1", int'(fully_muted), 0);
    strobe(-4321, 4321, "R1");
    check("R1", int'(left_out), -4321);

    // R2: full fade length
    @(negedge clk) mute_req = 1;
    n = 0;
    while (!fully_muted && n < 2000) begin
      strobe(12800, -12801, "R2");
      n++;
    end
    check("R2", n, GS * SS);
    strobe(-32768, 32767, "R4");
    check("R4", int'(left_out), 0);

    // R3: full return
    @(negedge clk) mute_req = 0;
    n = 0;
    do begin
      strobe(12800, -3, "R3");
      n++;
    end while (int'(left_out) != 12800 && n < 2000);
    check("R3", n, GS * SS + 1);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule